// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the next level of memory. The processor hands each store to the buffer and goes on at once. The buffer keeps a small number of entries. Each entry holds one block-aligned address, one word per slot of the block, and a mask that marks which slots hold data. A store that falls in a block already held by an entry is folded into that entry. A store to any other block takes a free entry. Entries leave for memory oldest first, one block per write transaction, and each transaction carries its word mask.

Read misses from the cache are checked against every buffered block before they go out.

- **Conflict, word present:** the read is answered straight from the buffer.
- **Conflict, word absent:** the read is held back until the missing word is buffered or the entry has drained.
- **No conflict:** the read takes the memory port ahead of any pending drain, so read misses never wait behind buffered writes.

All three data paths are valid/ready. The processor write port stalls only when every entry is in use and the store cannot merge. The read-query port is accepted in the cycle the read is either forwarded or taken by memory. On the memory port, a write transaction is re-offered each cycle until memory takes it. A read miss may displace the offered write for as long as the read is presented, without loss.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `mem_valid` is low and `wr_ready` is high.
- R2: A store to a block not held by any entry is accepted in the same cycle whenever fewer than DEPTH entries are in use, and it occupies a new entry.
- R3: A store to a block already held by an entry merges into that entry without using a new one: it sets that word's mask bit, and a later store to the same word replaces the earlier data.
- R4: Entries drain in allocation order, one block per memory write transaction (`mem_we`=1). `mem_addr` is block-aligned (low log2(WPB) bits zero). `mem_mask` bit i is set exactly for the words written, and word i sits at `mem_data[i*DATA_W +: DATA_W]`, with unwritten words zero. The entry is freed on the cycle `mem_valid` and `mem_ready` are both high.
- R5: When all DEPTH entries are in use, `wr_ready` is low for a store that cannot merge and nothing is stored. A store that merges is still accepted.
- R6: A read query whose word is held in a buffered entry gets `rd_ready`=1 and `rd_fwd`=1 in the same cycle, with `rd_data` equal to the newest buffered value of that word.
- R7: A read query that hits a buffered block whose mask lacks the word keeps `rd_ready` low and issues no memory read. Once that entry has drained, the read goes to memory.
- R8: A read query that hits no buffered block is placed on the memory port with `mem_we`=0 and the full word address, ahead of any pending drain. `rd_ready` then follows `mem_ready`, and no buffered entry is removed in that cycle.
- R9: A store to the block of the oldest entry, arriving in the cycle that entry is accepted by memory, does not merge into it. The store takes a new entry and leaves in a later transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Processor store offered |
| wr_ready | output | 1 | Store accepted this cycle (merge or free entry) |
| wr_addr | input | ADDR_W | Store word address |
| wr_data | input | DATA_W | Store data |
| rd_valid | input | 1 | Read-miss query offered |
| rd_ready | output | 1 | Query forwarded or taken by memory this cycle |
| rd_addr | input | ADDR_W | Read-miss word address |
| rd_fwd | output | 1 | Query answered from the buffer |
| rd_data | output | DATA_W | Forwarded word, valid with `rd_fwd` |
| mem_valid | output | 1 | Memory transaction offered |
| mem_ready | input | 1 | Memory takes the offered transaction |
| mem_we | output | 1 | 1 = block write from the buffer, 0 = read miss |
| mem_addr | output | ADDR_W | Block address for writes, word address for reads |
| mem_data | output | WPB*DATA_W | Block data, word i in slice i |
| mem_mask | output | WPB | Written-word mask for writes, zero for reads |

## Verification
Every handshake output (`wr_ready`, `rd_ready`, `rd_fwd`, `rd_data` and the whole memory port) is a combinational function of the stored entries and the present inputs. Each of these results is therefore due in the same cycle as its stimulus. Changes to the stored entries (allocation, merge, drain) show only after the next rising edge. The bench drives inputs just after a falling edge and samples 2 ns later, well before the rising edge that commits the cycle. A check of stored state is made in the cycle after the edge that committed it, typically by observing the next memory transaction.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  // Owner of the memory port in a given cycle.
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_READ  = 2'd1,
    PORT_DRAIN = 2'd2
  } port_owner_e;
endpackage

// File: rtl/mwb_match.sv
// Compares one query block tag against every entry, one comparator per slot.
module mwb_match #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0][TAG_W-1:0]  tags_i,
  input  logic [DEPTH-1:0]             excl_i,
  input  logic [TAG_W-1:0]             q_tag_i,
  output logic [DEPTH-1:0]             hit_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_o[g] = vld_i[g] && !excl_i[g] && (tags_i[g] == q_tag_i);
  end

  // At most one live entry per block: merging never lets a duplicate stay.
  p_hit_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_o));
endmodule

// File: rtl/mwb_store.sv
// Entry storage kept as a ring. DEPTH must be a power of two.
module mwb_store #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 10,
  parameter int WPB    = 4,
  parameter int DATA_W = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    push_i,
  input  logic [DEPTH-1:0]                        merge_i,
  input  logic [TAG_W-1:0]                        tag_i,
  input  logic [$clog2(WPB)-1:0]                  off_i,
  input  logic [DATA_W-1:0]                       data_i,
  input  logic                                    pop_i,
  output logic [DEPTH-1:0]                        vld_o,
  output logic [DEPTH-1:0][TAG_W-1:0]             tag_o,
  output logic [DEPTH-1:0][WPB-1:0][DATA_W-1:0]   data_o,
  output logic [DEPTH-1:0][WPB-1:0]               mask_o,
  output logic [$clog2(DEPTH)-1:0]                head_o,
  output logic                                    full_o,
  output logic                                    empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] tail;

  assign tail    = head_q + cnt_q[PTR_W-1:0];
  assign head_o  = head_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      vld_o  <= '0;
      tag_o  <= '0;
      data_o <= '0;
      mask_o <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (merge_i[i]) begin
          data_o[i][off_i] <= data_i;
          mask_o[i][off_i] <= 1'b1;
        end
        if (push_i && (tail == PTR_W'(i))) begin
          vld_o[i]         <= 1'b1;
          tag_o[i]         <= tag_i;
          mask_o[i]        <= WPB'(1) << off_i;
          data_o[i]        <= '0;
          data_o[i][off_i] <= data_i;
        end
        if (pop_i && (head_q == PTR_W'(i))) begin
          vld_o[i] <= 1'b0;
        end
      end
      if (pop_i) head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < CNT_W'(DEPTH) || pop_i));
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> vld_o[head_q]);
  p_count_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_o) == int'(cnt_q));
endmodule

// File: rtl/mwb_port_arb.sv
// Decides who owns the memory port: a non-conflicting read first, then drain.
module mwb_port_arb
  import mwb_pkg::*;
(
  input  logic        rd_req_i,
  input  logic        drain_req_i,
  input  logic        mem_ready_i,
  output port_owner_e owner_o,
  output logic        rd_go_o,
  output logic        drain_go_o
);
  always_comb begin
    if (rd_req_i)         owner_o = PORT_READ;
    else if (drain_req_i) owner_o = PORT_DRAIN;
    else                  owner_o = PORT_IDLE;
  end
  assign rd_go_o    = mem_ready_i && (owner_o == PORT_READ);
  assign drain_go_o = mem_ready_i && (owner_o == PORT_DRAIN);
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
  import mwb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int WPB    = 4,
  parameter int DEPTH  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   rd_valid,
  output logic                   rd_ready,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic                   rd_fwd,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   mem_valid,
  input  logic                   mem_ready,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [WPB*DATA_W-1:0]  mem_data,
  output logic [WPB-1:0]         mem_mask
);
  localparam int OFF_W = $clog2(WPB);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0]                      ent_vld;
  logic [DEPTH-1:0][TAG_W-1:0]           ent_tag;
  logic [DEPTH-1:0][WPB-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0][WPB-1:0]             ent_mask;
  logic [PTR_W-1:0]                      head;
  logic                                  full, empty;

  logic [TAG_W-1:0] wr_tag, rd_tag;
  logic [OFF_W-1:0] wr_off, rd_off;
  assign wr_tag = wr_addr[ADDR_W-1:OFF_W];
  assign wr_off = wr_addr[OFF_W-1:0];
  assign rd_tag = rd_addr[ADDR_W-1:OFF_W];
  assign rd_off = rd_addr[OFF_W-1:0];

  // Read side: conflict check against all live entries.
  logic [DEPTH-1:0] rd_hit;
  mwb_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_rd_match (
    .clk(clk), .rst_n(rst_n), .vld_i(ent_vld), .tags_i(ent_tag),
    .excl_i('0), .q_tag_i(rd_tag), .hit_o(rd_hit));

  logic             rd_conf, rd_word_ok;
  logic [DATA_W-1:0] fwd_word;
  always_comb begin
    rd_word_ok = 1'b0;
    fwd_word   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_hit[i]) begin
        rd_word_ok = rd_word_ok | ent_mask[i][rd_off];
        fwd_word   = fwd_word | ent_data[i][rd_off];
      end
    end
  end
  assign rd_conf = |rd_hit;

  // Memory port arbitration.
  port_owner_e owner;
  logic        rd_req_mem, rd_go, drain_go;
  assign rd_req_mem = rd_valid && !rd_conf;
  mwb_port_arb u_arb (
    .rd_req_i(rd_req_mem), .drain_req_i(!empty), .mem_ready_i(mem_ready),
    .owner_o(owner), .rd_go_o(rd_go), .drain_go_o(drain_go));

  // Write side: merge target, never the head while it is being accepted.
  logic [DEPTH-1:0] head_oh, wr_excl, wr_hit, merge_vec;
  logic             wr_merge, wr_fire, push;
  assign head_oh = DEPTH'(1) << head;
  assign wr_excl = drain_go ? head_oh : '0;
  mwb_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_wr_match (
    .clk(clk), .rst_n(rst_n), .vld_i(ent_vld), .tags_i(ent_tag),
    .excl_i(wr_excl), .q_tag_i(wr_tag), .hit_o(wr_hit));
  assign wr_merge  = |wr_hit;
  assign wr_ready  = wr_merge || !full;
  assign wr_fire   = wr_valid && wr_ready;
  assign push      = wr_fire && !wr_merge;
  assign merge_vec = wr_fire ? wr_hit : '0;

  mwb_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .WPB(WPB), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push_i(push), .merge_i(merge_vec),
    .tag_i(wr_tag), .off_i(wr_off), .data_i(wr_data), .pop_i(drain_go),
    .vld_o(ent_vld), .tag_o(ent_tag), .data_o(ent_data), .mask_o(ent_mask),
    .head_o(head), .full_o(full), .empty_o(empty));

  // Outputs.
  assign rd_ready  = rd_conf ? rd_word_ok : mem_ready;
  assign rd_fwd    = rd_valid && rd_conf && rd_word_ok;
  assign rd_data   = fwd_word;
  assign mem_valid = (owner != PORT_IDLE);
  assign mem_we    = (owner == PORT_DRAIN);
  assign mem_addr  = (owner == PORT_READ) ? rd_addr : {ent_tag[head], {OFF_W{1'b0}}};
  assign mem_data  = (owner == PORT_DRAIN) ? ent_data[head] : '0;
  assign mem_mask  = (owner == PORT_DRAIN) ? ent_mask[head] : '0;

  // Checks next to the port logic.
  p_reset_empty_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!mem_valid && wr_ready));
  p_aligned_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_addr[OFF_W-1:0] == '0 && mem_mask != '0));
  p_fwd_needs_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fwd |-> rd_ready);
  p_stall_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !mem_ready) |-> !(mem_valid && !mem_we) || !rd_conf);
  p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_conf && !rd_word_ok) |-> !(mem_valid && !mem_we));
  p_read_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_conf) |-> (mem_valid && !mem_we && mem_addr == rd_addr));
  p_merge_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_merge && !drain_go) |=> $stable(ent_vld));
  p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !wr_merge) |-> !wr_ready);
endmodule

// File: tb/tb_merge_wbuf.sv
module tb_merge_wbuf;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int WPB    = 4;
  localparam int DEPTH  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0, mem_ready = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_ready, rd_ready, rd_fwd, mem_valid, mem_we;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] mem_addr;
  logic [WPB*DATA_W-1:0] mem_data;
  logic [WPB-1:0] mem_mask;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  merge_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WPB(WPB), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_fwd(rd_fwd), .rd_data(rd_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_mask(mem_mask));

  // Store vectors: {address, data, expected wr_ready}
  localparam logic [ADDR_W+DATA_W:0] WVEC [6] = '{
    {12'h010, 16'h1111, 1'b1},
    {12'h012, 16'h2222, 1'b1},
    {12'h025, 16'h3333, 1'b1},
    {12'h011, 16'h4444, 1'b1},
    {12'h012, 16'h5555, 1'b1},
    {12'h03F, 16'h6666, 1'b1}
  };
  // Expected drains: {block address, mask, data}
  localparam logic [ADDR_W+WPB+WPB*DATA_W-1:0] DVEC [3] = '{
    {12'h010, 4'b0111, 64'h0000_5555_4444_1111},
    {12'h024, 4'b0010, 64'h0000_0000_3333_0000},
    {12'h03C, 4'b1000, 64'h6666_0000_0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    #2;
    chk("R1 mem_valid", 64'(mem_valid), 64'd0);
    chk("R1 wr_ready", 64'(wr_ready), 64'd1);

    // R2/R3: vector table of stores, memory stalled
    for (int v = 0; v < 6; v++) begin
      wr_valid = 1'b1;
      wr_addr  = WVEC[v][ADDR_W+DATA_W:DATA_W+1];
      wr_data  = WVEC[v][DATA_W:1];
      #2;
      chk("R2 R3 wr_ready", 64'(wr_ready), 64'(WVEC[v][0]));
      tick();
    end
    wr_valid = 1'b0;

    // R6: forward present words, R3 newest value
    rd_valid = 1'b1; rd_addr = 12'h011;
    #2;
    chk("R6 rd_ready", 64'(rd_ready), 64'd1);
    chk("R6 rd_fwd", 64'(rd_fwd), 64'd1);
    chk("R6 rd_data", 64'(rd_data), 64'h4444);
    tick();
    rd_addr = 12'h012;
    #2;
    chk("R3 overwrite fwd", 64'(rd_data), 64'h5555);
    tick();
    // R7: conflict, word absent
    rd_addr = 12'h013;
    #2;
    chk("R7 stall rd_ready", 64'(rd_ready), 64'd0);
    chk("R7 no mem read", 64'(mem_we), 64'd1);
    tick();
    // R8: no conflict read goes first
    rd_addr = 12'h100;
    #2;
    chk("R8 mem_valid", 64'(mem_valid), 64'd1);
    chk("R8 mem_we", 64'(mem_we), 64'd0);
    chk("R8 mem_addr", 64'(mem_addr), 64'h100);
    chk("R8 rd_ready low", 64'(rd_ready), 64'd0);
    tick();
    mem_ready = 1'b1;
    #2;
    chk("R8 rd_ready follows", 64'(rd_ready), 64'd1);
    tick();
    rd_valid = 1'b0; mem_ready = 1'b0;
    #2;
    chk("R8 head kept", 64'(mem_addr), 64'h010);

    // R4: drain in order
    mem_ready = 1'b1;
    for (int d = 0; d < 3; d++) begin
      #2;
      chk("R4 mem_valid", 64'(mem_valid), 64'd1);
      chk("R4 mem_we", 64'(mem_we), 64'd1);
      chk("R4 mem_addr", 64'(mem_addr), 64'(DVEC[d][ADDR_W+WPB+WPB*DATA_W-1:WPB+WPB*DATA_W]));
      chk("R4 mem_mask", 64'(mem_mask), 64'(DVEC[d][WPB+WPB*DATA_W-1:WPB*DATA_W]));
      chk("R4 mem_data", mem_data, DVEC[d][WPB*DATA_W-1:0]);
      tick();
    end
    #2;
    chk("R4 empty", 64'(mem_valid), 64'd0);

    // R7: stall releases after drain
    mem_ready = 1'b0;
    wr_valid = 1'b1; wr_addr = 12'h040; wr_data = 16'h7777;
    tick();
    wr_valid = 1'b0;
    rd_valid = 1'b1; rd_addr = 12'h041; mem_ready = 1'b1;
    #2;
    chk("R7 stall rd_ready", 64'(rd_ready), 64'd0);
    chk("R7 drain addr", 64'(mem_addr), 64'h040);
    tick();
    #2;
    chk("R7 released rd_ready", 64'(rd_ready), 64'd1);
    chk("R7 released mem_we", 64'(mem_we), 64'd0);
    chk("R7 released addr", 64'(mem_addr), 64'h041);
    tick();
    rd_valid = 1'b0;

    // R5: full buffer
    mem_ready = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      wr_valid = 1'b1; wr_addr = 12'h080 + 12'(4 * k); wr_data = 16'hA000 + 16'(k);
      tick();
    end
    wr_addr = 12'h090; wr_data = 16'hEEEE;
    #2;
    chk("R5 full blocks", 64'(wr_ready), 64'd0);
    tick();
    wr_addr = 12'h081; wr_data = 16'hB001;
    #2;
    chk("R5 full merges", 64'(wr_ready), 64'd1);
    tick();
    wr_valid = 1'b0; mem_ready = 1'b1;
    #2;
    chk("R5 merged addr", 64'(mem_addr), 64'h080);
    chk("R5 merged mask", 64'(mem_mask), 64'b0011);
    chk("R5 merged data", mem_data, 64'h0000_0000_B001_A000);
    tick();
    for (int k = 1; k < DEPTH; k++) begin
      #2;
      chk("R5 drain addr", 64'(mem_addr), 64'h080 + 64'(4 * k));
      tick();
    end
    #2;
    chk("R5 rejected not stored", 64'(mem_valid), 64'd0);

    // R9: store to head block while head is accepted
    mem_ready = 1'b0;
    wr_valid = 1'b1; wr_addr = 12'h0A0; wr_data = 16'hC0C0;
    tick();
    mem_ready = 1'b1; wr_addr = 12'h0A1; wr_data = 16'hC1C1;
    #2;
    chk("R9 wr_ready", 64'(wr_ready), 64'd1);
    chk("R9 head mask", 64'(mem_mask), 64'b0001);
    tick();
    wr_valid = 1'b0;
    #2;
    chk("R9 second tx addr", 64'(mem_addr), 64'h0A0);
    chk("R9 second tx mask", 64'(mem_mask), 64'b0010);
    chk("R9 second tx data", mem_data, 64'h0000_0000_C1C1_0000);
    tick();
    #2;
    chk("R9 empty", 64'(mem_valid), 64'd0);

    // R1: reset clears held entries
    mem_ready = 1'b0;
    wr_valid = 1'b1; wr_addr = 12'h0B0; wr_data = 16'h1234;
    tick();
    wr_valid = 1'b0; rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    #2;
    chk("R1 reset empties", 64'(mem_valid), 64'd0);
    chk("R1 reset wr_ready", 64'(wr_ready), 64'd1);
    tick();
    finish_run();
  end
endmodule